// File: doc/BRIEF.md
# Test-pattern colour selector for a raster display

This block sits between a raster timing generator and the colour pins of a display port. Each clock it takes the current pixel column, a blanking flag and the raw horizontal and vertical sync levels from the timing generator. It also takes three mode buttons and a 12-bit switch word. From these it picks the colour for the current pixel.

The colour sources are ranked. Blanking always wins and gives black. After that come a button that forces black, a button that forces white, and a button that shows one solid colour taken from the switches. With no button pressed, the block draws eight vertical colour bars across the visible width.

The chosen colour and both sync levels are captured in output flip-flops on every clock. The display therefore sees glitch-free signals, and sync and colour arrive with the same one-cycle delay.

Top module: `bar_color_mux`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `red`=`grn`=`blu`=4'h0 and `hs_out`=`vs_out`=1, whatever the other inputs are.
- R2: When `blank_in` is 1, the colour outputs become 4'h0 on all three channels, whatever the buttons and switches are.
- R3: With `blank_in`=0 and `btn_black`=1, the colour is black (4'h0 on every channel), even if `btn_white` or `btn_sw` is also pressed.
- R4: With `blank_in`=0, `btn_black`=0 and `btn_white`=1, the colour is white (4'hF on every channel), even if `btn_sw` is pressed.
- R5: With `blank_in`=0, only `btn_sw` pressed, the colour is `red`=`sw[11:8]`, `grn`=`sw[7:4]` and `blu`=`sw[3:0]`, for any column.
- R6: With `blank_in`=0 and no button pressed, bar index k = `col`/80 (clamped to 7 for columns at or beyond 560). Each channel is all ones or all zeros: `blu` follows bit 0 of k, `grn` bit 1 and `red` bit 2. From left to right this gives black, blue, green, cyan, red, magenta, yellow and white, with bar edges at 80, 160, 240, 320, 400, 480 and 560.
- R7: `hs_out` and `vs_out` equal `hs_in` and `vs_in` from the previous clock edge. They are unaffected by blanking, buttons or switches.
- R8: Every output changes exactly one clock edge after the inputs that select it, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; outputs update on every rising edge |
| rst | input | 1 | Synchronous reset, active high |
| col | input | 10 | Current pixel column from the timing generator |
| blank_in | input | 1 | High while the current pixel is in a retrace interval |
| hs_in | input | 1 | Raw horizontal sync from the timing generator (active low) |
| vs_in | input | 1 | Raw vertical sync from the timing generator (active low) |
| btn_black | input | 1 | Forces black |
| btn_white | input | 1 | Forces white |
| btn_sw | input | 1 | Shows the switch colour |
| sw | input | 12 | Solid colour: red [11:8], green [7:4], blue [3:0] |
| red | output | 4 | Registered red channel |
| grn | output | 4 | Registered green channel |
| blu | output | 4 | Registered blue channel |
| hs_out | output | 1 | Registered horizontal sync |
| vs_out | output | 1 | Registered vertical sync |

## Verification
Blanking and the button overrides can both be active in the same cycle. The bench drives blanking with every button and a non-zero switch word, then presses the buttons together in descending pairs. Each result is judged against the rank order.

Sync pass-through and colour forcing also share a cycle. Sync levels are toggled while blank and buttons change, and the bench checks that sync lags by one edge and is never altered by the colour path. Column values on both sides of every bar edge confirm the bar index.

// File: rtl/bar_color_mux.sv
module bar_color_mux #(
  parameter int COL_W = 10,
  parameter int CH_W  = 4,
  parameter int BAR_W = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COL_W-1:0]  col,
  input  logic              blank_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              btn_black,
  input  logic              btn_white,
  input  logic              btn_sw,
  input  logic [3*CH_W-1:0] sw,
  output logic [CH_W-1:0]   red,
  output logic [CH_W-1:0]   grn,
  output logic [CH_W-1:0]   blu,
  output logic              hs_out,
  output logic              vs_out
);
  localparam int N_BARS = 8;
  localparam int IDX_W  = $clog2(N_BARS);

  logic [IDX_W-1:0] idx;
  logic [CH_W-1:0]  r_nx, g_nx, b_nx;

  always_comb begin
    idx = '0;
    for (int i = 1; i < N_BARS; i++)
      if (int'(col) >= i * BAR_W) idx = IDX_W'(i);
  end

  always_comb begin
    if (blank_in || btn_black) begin
      r_nx = '0; g_nx = '0; b_nx = '0;
    end else if (btn_white) begin
      r_nx = '1; g_nx = '1; b_nx = '1;
    end else if (btn_sw) begin
      r_nx = sw[3*CH_W-1:2*CH_W];
      g_nx = sw[2*CH_W-1:CH_W];
      b_nx = sw[CH_W-1:0];
    end else begin
      r_nx = {CH_W{idx[2]}};
      g_nx = {CH_W{idx[1]}};
      b_nx = {CH_W{idx[0]}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      red <= '0; grn <= '0; blu <= '0;
      hs_out <= 1'b1; vs_out <= 1'b1;
    end else begin
      red <= r_nx; grn <= g_nx; blu <= b_nx;
      hs_out <= hs_in; vs_out <= vs_in;
    end
  end
endmodule

module bar_color_mux_chk (
  input logic        clk,
  input logic        rst,
  input logic [9:0]  col,
  input logic        blank_in,
  input logic        hs_in,
  input logic        vs_in,
  input logic        btn_black,
  input logic        btn_white,
  input logic        btn_sw,
  input logic [11:0] sw,
  input logic [3:0]  red,
  input logic [3:0]  grn,
  input logic [3:0]  blu,
  input logic        hs_out,
  input logic        vs_out
);
  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (red == 4'h0 && grn == 4'h0 && blu == 4'h0 && hs_out && vs_out));
  // R2
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    blank_in |=> (red == 4'h0 && grn == 4'h0 && blu == 4'h0));
  // R3
  black_btn_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_in && btn_black) |=> (red == 4'h0 && grn == 4'h0 && blu == 4'h0));
  // R4
  white_btn_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_in && !btn_black && btn_white) |=> (red == 4'hF && grn == 4'hF && blu == 4'hF));
  // R5
  sw_color_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_in && !btn_black && !btn_white && btn_sw) |=> ({red, grn, blu} == $past(sw)));
  // R7
  sync_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hs_out == $past(hs_in) && vs_out == $past(vs_in)));
endmodule

bind bar_color_mux bar_color_mux_chk u_chk (.*);

// File: tb/sim_bar_color_mux.sv
module sim_bar_color_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  // {col, blank, black, white, swbtn, sw, hs, vs, expected rgb, requirement}
  localparam logic [43:0] VEC [NV] = '{
    // R6 bar edges
    {10'd0,   1'b0, 3'b000, 12'h000, 2'b11, 12'h000, 4'd6},
    {10'd79,  1'b0, 3'b000, 12'h000, 2'b01, 12'h000, 4'd6},
    {10'd80,  1'b0, 3'b000, 12'h000, 2'b10, 12'h00F, 4'd6},
    {10'd159, 1'b0, 3'b000, 12'h000, 2'b00, 12'h00F, 4'd6},
    {10'd160, 1'b0, 3'b000, 12'h000, 2'b11, 12'h0F0, 4'd6},
    {10'd239, 1'b0, 3'b000, 12'h000, 2'b11, 12'h0F0, 4'd6},
    {10'd240, 1'b0, 3'b000, 12'h000, 2'b01, 12'h0FF, 4'd6},
    {10'd319, 1'b0, 3'b000, 12'h000, 2'b11, 12'h0FF, 4'd6},
    {10'd320, 1'b0, 3'b000, 12'h000, 2'b10, 12'hF00, 4'd6},
    {10'd399, 1'b0, 3'b000, 12'h000, 2'b11, 12'hF00, 4'd6},
    {10'd400, 1'b0, 3'b000, 12'h000, 2'b11, 12'hF0F, 4'd6},
    {10'd479, 1'b0, 3'b000, 12'h000, 2'b00, 12'hF0F, 4'd6},
    {10'd480, 1'b0, 3'b000, 12'h000, 2'b11, 12'hFF0, 4'd6},
    {10'd559, 1'b0, 3'b000, 12'h000, 2'b11, 12'hFF0, 4'd6},
    {10'd560, 1'b0, 3'b000, 12'h000, 2'b01, 12'hFFF, 4'd6},
    {10'd639, 1'b0, 3'b000, 12'h000, 2'b11, 12'hFFF, 4'd6},
    {10'd700, 1'b0, 3'b000, 12'h000, 2'b11, 12'hFFF, 4'd6},
    // R2 blank beats every button
    {10'd100, 1'b1, 3'b111, 12'hABC, 2'b10, 12'h000, 4'd2},
    {10'd600, 1'b1, 3'b000, 12'hFFF, 2'b01, 12'h000, 4'd2},
    // R3 black beats white and switch colour
    {10'd200, 1'b0, 3'b111, 12'hABC, 2'b11, 12'h000, 4'd3},
    {10'd200, 1'b0, 3'b101, 12'hABC, 2'b11, 12'h000, 4'd3},
    // R4 white beats switch colour
    {10'd50,  1'b0, 3'b011, 12'h123, 2'b00, 12'hFFF, 4'd4},
    {10'd50,  1'b0, 3'b010, 12'h123, 2'b11, 12'hFFF, 4'd4},
    // R5 switch colour, several words and columns
    {10'd10,  1'b0, 3'b001, 12'hABC, 2'b11, 12'hABC, 4'd5},
    {10'd639, 1'b0, 3'b001, 12'h5A3, 2'b11, 12'h5A3, 4'd5},
    {10'd330, 1'b0, 3'b001, 12'h000, 2'b10, 12'h000, 4'd5},
    {10'd90,  1'b0, 3'b001, 12'hF0F, 2'b01, 12'hF0F, 4'd5}
  };

  logic clk = 0, rst = 1;
  logic [9:0] col = '0;
  logic blank_in = 0, hs_in = 1, vs_in = 1;
  logic btn_black = 0, btn_white = 0, btn_sw = 0;
  logic [11:0] sw = '0;
  logic [3:0] red, grn, blu;
  logic hs_out, vs_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_color_mux u0 (.clk, .rst, .col, .blank_in, .hs_in, .vs_in,
    .btn_black, .btn_white, .btn_sw, .sw, .red, .grn, .blu, .hs_out, .vs_out);

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got rgb/hs/vs %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [43:0] v);
    {col, blank_in, btn_black, btn_white, btn_sw, sw, hs_in, vs_in} = v[43:16];
  endtask

  initial begin
    @(negedge clk);
    btn_white = 1; hs_in = 0; vs_in = 0;
    @(posedge clk); #1;
    // R1 reset state ignores inputs
    check("R1", {red, grn, blu, hs_out, vs_out}, {12'h000, 2'b11});
    @(negedge clk); rst = 0; btn_white = 0; hs_in = 1; vs_in = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk); #1;
      check($sformatf("R%0d", VEC[i][3:0]), {red, grn, blu, hs_out, vs_out},
            {VEC[i][15:4], VEC[i][17:16]});
      // R7 sync delayed copy in every vector
      check("R7", {12'h000, hs_out, vs_out}, {12'h000, VEC[i][17:16]});
    end

    // R8 one-edge latency: old value holds until the edge
    @(negedge clk);
    col = 10'd0; blank_in = 0; {btn_black, btn_white, btn_sw} = 3'b010; hs_in = 1; vs_in = 1;
    @(posedge clk); #1;
    check("R8", {red, grn, blu, hs_out, vs_out}, {12'hFFF, 2'b11});
    @(negedge clk);
    btn_white = 0; hs_in = 0; vs_in = 0;
    #(CLK_PERIOD/2 - 1);
    check("R8", {red, grn, blu, hs_out, vs_out}, {12'hFFF, 2'b11});
    @(posedge clk); #1;
    check("R8", {red, grn, blu, hs_out, vs_out}, {12'h000, 2'b00});

    // R7 sync not disturbed by blank toggling
    @(negedge clk); blank_in = 1; hs_in = 1; vs_in = 0;
    @(posedge clk); #1;
    check("R7", {red, grn, blu, hs_out, vs_out}, {12'h000, 2'b10});
    @(negedge clk); blank_in = 0; hs_in = 0; vs_in = 1; col = 10'd560;
    @(posedge clk); #1;
    check("R7", {red, grn, blu, hs_out, vs_out}, {12'hFFF, 2'b01});

    // R1 reset re-entered mid-pattern
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R1", {red, grn, blu, hs_out, vs_out}, {12'h000, 2'b11});
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got no finish expected finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule